// File: doc/BRIEF.md
# Deferred Condition-Flag Evaluator

This block rebuilds the four arithmetic condition flags (negative, zero, carry, overflow) from a deferred-flags record instead of from a stored flag register. A processor front end that postpones flag computation keeps only an operation tag and three saved operand words. When a later consumer needs the flags, the record is presented here and the flags are recomputed from the operands with the rule that belongs to that tag.

Each operation kind keeps its operands in its own way. Add and subtract keep both source operands. The carry-chained forms also keep the incoming carry. Logical operations keep the result, the shifter carry-out and the previous overflow. The multiplies keep the product and a packed previous carry/overflow pair. The output is a 32-bit word with the flags in its top four bits and zeros below them. A separate error strobe marks a tag that has no defined rule. By default the outputs pass through one register stage. A parameter removes that stage and leaves a purely combinational path.

Top module: `nzcv_thunk_eval`

## Requirements
- R1: Tag 0 (copy) takes N, Z, C, V from operand A bits 31, 30, 29, 28. Operand B, the carry operand and operand A bits 27:0 have no effect.
- R2: Tag 1 (add) forms A+B. C is set on unsigned carry-out. V is set on signed overflow. N is result bit 31. Z is set when the 32-bit result is zero.
- R3: Tag 2 (subtract) forms A-B. C is set when A is unsigned greater than or equal to B. V is set on signed overflow. N and Z follow the result.
- R4: Tag 3 (add with carry) forms A+B+k, where k is carry-operand bit 0. C is the unsigned carry-out of that sum. V is its signed overflow. Carry-operand bits 31:1 must be zero.
- R5: Tag 4 (subtract with carry) forms A-B-(1-k). C is A>=B (unsigned) when k is 1 and A>B when k is 0. V is signed overflow. N and Z follow the result.
- R6: Tag 5 (logical) takes N and Z from operand A as the result. C is operand B bit 0. V is carry-operand bit 0.
- R7: Tag 6 (multiply) takes N and Z from operand A. C is carry-operand bit 1 and V is carry-operand bit 0. Operand B has no effect.
- R8: Tag 7 (long multiply) treats A as the low half and B as the high half of a 64-bit product. N is B bit 31. Z is set only when both halves are zero. C and V come from carry-operand bits 1 and 0.
- R9: Tags 8 to 15 raise the error strobe and drive all four flags to zero. Tags 0 to 7 keep the strobe low.
- R10: Output bits 27:0 are always zero.
- R11: With the register stage present, the outputs reflect the inputs one rising clock edge later. An active-low reset clears the flag word and the strobe at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 4 | Operation tag of the deferred record |
| dep1 | input | 32 | Operand A |
| dep2 | input | 32 | Operand B |
| ndep | input | 32 | Carry operand (previous carry and/or overflow) |
| flags | output | 32 | N, Z, C, V in bits 31..28, zeros below |
| bad_op | output | 1 | High for an undefined tag |

## Verification
The flag word and the error strobe both come from the same output register, so each result is due exactly one rising edge after its record is applied. The bench drives each record on a falling edge and reads both outputs on the next falling edge. That read falls after the capturing edge and before the next record is applied. The reset check runs without any clock edge: reset is asserted in mid-run and the outputs are read one nanosecond later, while the last result is still held in the register.

// File: rtl/nzcv_thunk_eval.sv
module nzcv_thunk_eval #(
  parameter int W       = 32,
  parameter int TAG_W   = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] op,
  input  logic [W-1:0]     dep1,
  input  logic [W-1:0]     dep2,
  input  logic [W-1:0]     ndep,
  output logic [W-1:0]     flags,
  output logic             bad_op
);
  localparam int NB = W - 1;
  localparam int ZB = W - 2;
  localparam int CB = W - 3;
  localparam int VB = W - 4;

  localparam logic [TAG_W-1:0] OP_COPY  = TAG_W'(0);
  localparam logic [TAG_W-1:0] OP_ADD   = TAG_W'(1);
  localparam logic [TAG_W-1:0] OP_SUB   = TAG_W'(2);
  localparam logic [TAG_W-1:0] OP_ADC   = TAG_W'(3);
  localparam logic [TAG_W-1:0] OP_SBB   = TAG_W'(4);
  localparam logic [TAG_W-1:0] OP_LOGIC = TAG_W'(5);
  localparam logic [TAG_W-1:0] OP_MUL   = TAG_W'(6);
  localparam logic [TAG_W-1:0] OP_MULL  = TAG_W'(7);

  // one adder for add/adc, one for sub/sbb (sub as A + ~B + cin)
  logic         add_cin, sub_cin;
  logic [W:0]   add_w, sub_w;
  logic [W-1:0] add_r, sub_r;
  logic         add_v, sub_v;

  assign add_cin = (op == OP_ADC) & ndep[0];
  assign sub_cin = (op == OP_SUB) | ((op == OP_SBB) & ndep[0]);
  assign add_w   = {1'b0, dep1} + {1'b0, dep2} + {{W{1'b0}}, add_cin};
  assign sub_w   = {1'b0, dep1} + {1'b0, ~dep2} + {{W{1'b0}}, sub_cin};
  assign add_r   = add_w[W-1:0];
  assign sub_r   = sub_w[W-1:0];
  assign add_v   = (add_r[NB] ^ dep1[NB]) & (add_r[NB] ^ dep2[NB]);
  assign sub_v   = (dep1[NB] ^ dep2[NB]) & (dep1[NB] ^ sub_r[NB]);

  logic       n, z, c, v, bad;
  logic [W-1:0] word;

  always_comb begin
    n = 1'b0; z = 1'b0; c = 1'b0; v = 1'b0; bad = 1'b0;
    case (op)
      OP_COPY: begin
        n = dep1[NB]; z = dep1[ZB]; c = dep1[CB]; v = dep1[VB];
      end
      OP_ADD, OP_ADC: begin
        n = add_r[NB]; z = (add_r == '0); c = add_w[W]; v = add_v;
      end
      OP_SUB, OP_SBB: begin
        n = sub_r[NB]; z = (sub_r == '0); c = sub_w[W]; v = sub_v;
      end
      OP_LOGIC: begin
        n = dep1[NB]; z = (dep1 == '0); c = dep2[0]; v = ndep[0];
      end
      OP_MUL: begin
        n = dep1[NB]; z = (dep1 == '0); c = ndep[1]; v = ndep[0];
      end
      OP_MULL: begin
        n = dep2[NB]; z = ((dep1 | dep2) == '0); c = ndep[1]; v = ndep[0];
      end
      default: bad = 1'b1;
    endcase
  end

  assign word = {n, z, c, v, {(W-4){1'b0}}};

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          flags  <= '0;
          bad_op <= 1'b0;
        end else begin
          flags  <= word;
          bad_op <= bad;
        end
      end

      p_low_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flags[VB-1:0] == '0);
      p_bad_tag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        op[TAG_W-1] |=> (bad_op && flags == '0));
      p_good_tag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !op[TAG_W-1] |=> !bad_op);
      p_copy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_COPY) |=> flags[NB:VB] == $past(dep1[NB:VB]));
      p_logic_cv_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LOGIC) |=> (flags[CB] == $past(dep2[0]) && flags[VB] == $past(ndep[0])));
      p_mul_cv_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_MUL || op == OP_MULL) |=> flags[CB:VB] == $past(ndep[1:0]));
      p_carry_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ADC || op == OP_SBB || op == OP_LOGIC) |-> ndep[W-1:1] == '0);
      p_pair_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_MUL || op == OP_MULL) |-> ndep[W-1:2] == '0);
      p_shco_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LOGIC) |-> dep2[W-1:1] == '0);
    end else begin : g_comb
      assign flags  = word;
      assign bad_op = bad;
    end
  endgenerate
endmodule

// File: tb/sim_nzcv_thunk_eval.sv
`timescale 1ns/1ps
module sim_nzcv_thunk_eval;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op = '0;
  logic [31:0] dep1 = '0, dep2 = '0, ndep = '0;
  logic [31:0] flags;
  logic        bad_op;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  nzcv_thunk_eval u0 (.clk(clk), .rst_n(rst_n), .op(op), .dep1(dep1),
                      .dep2(dep2), .ndep(ndep), .flags(flags), .bad_op(bad_op));

  localparam int NV = 18;
  localparam logic [3:0]  T_OP [NV] = '{4'd0, 4'd1, 4'd1, 4'd2, 4'd2, 4'd2, 4'd3, 4'd3, 4'd4,
                                        4'd4, 4'd5, 4'd6, 4'd7, 4'd7, 4'd7, 4'd9, 4'd15, 4'd0};
  localparam logic [31:0] T_A  [NV] = '{32'hA000_0000, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'd5, 32'd0,
                                        32'h8000_0000, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'd5, 32'd5,
                                        32'd0, 32'h8000_0000, 32'd0, 32'd1, 32'h8000_0000,
                                        32'hFFFF_FFFF, 32'h1234_5678, 32'h5FFF_FFFF};
  localparam logic [31:0] T_B  [NV] = '{32'hFFFF_FFFF, 32'd1, 32'd1, 32'd5, 32'd1, 32'd1, 32'd0,
                                        32'd0, 32'd5, 32'd5, 32'd1, 32'hFFFF_FFFF, 32'd0,
                                        32'h8000_0000, 32'd0, 32'd0, 32'd7, 32'd0};
  localparam logic [31:0] T_K  [NV] = '{32'hFFFF_FFFF, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd1,
                                        32'd0, 32'd0, 32'd1, 32'd1, 32'd2, 32'd1, 32'd3, 32'd0,
                                        32'd0, 32'd0, 32'd0};
  // {bad, N, Z, C, V}
  localparam logic [4:0]  T_X  [NV] = '{5'b01010, 5'b01001, 5'b00110, 5'b00110, 5'b01000,
                                        5'b00011, 5'b00110, 5'b00000, 5'b01000, 5'b00110,
                                        5'b00111, 5'b01010, 5'b00101, 5'b01011, 5'b00000,
                                        5'b10000, 5'b10000, 5'b00101};

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3: return "R4";
      4'd4: return "R5";
      4'd5: return "R6";
      4'd6: return "R7";
      4'd7: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [3:0] ref_nzcv(input logic [3:0] o, input logic [31:0] a,
                                          input logic [31:0] b, input logic [31:0] k);
    logic [63:0] r;
    longint sa, sb, ss;
    logic cn, cz, cc, cv;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    cn = 0; cz = 0; cc = 0; cv = 0;
    case (o)
      4'd0: {cn, cz, cc, cv} = a[31:28];
      4'd1, 4'd3: begin
        r  = {32'd0, a} + {32'd0, b} + ((o == 4'd3) ? {63'd0, k[0]} : 64'd0);
        ss = sa + sb + ((o == 4'd3) ? longint'(k[0]) : 0);
        cn = r[31]; cz = (r[31:0] == 0); cc = r[32];
        cv = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
      end
      4'd2, 4'd4: begin
        r  = {32'd0, a} - {32'd0, b} - ((o == 4'd4 && !k[0]) ? 64'd1 : 64'd0);
        ss = sa - sb - ((o == 4'd4 && !k[0]) ? 1 : 0);
        cn = r[31]; cz = (r[31:0] == 0);
        cc = (o == 4'd2 || k[0]) ? (a >= b) : (a > b);
        cv = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
      end
      4'd5: begin cn = a[31]; cz = (a == 0); cc = b[0]; cv = k[0]; end
      4'd6: begin cn = a[31]; cz = (a == 0); cc = k[1]; cv = k[0]; end
      4'd7: begin cn = b[31]; cz = ({b, a} == 64'd0); cc = k[1]; cv = k[0]; end
      default: ;
    endcase
    return {cn, cz, cc, cv};
  endfunction

  task automatic check(input string req, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] k);
    @(negedge clk);
    op = o; dep1 = a; dep2 = b; ndep = k;
    @(negedge clk);
  endtask

  function automatic logic [31:0] pick();
    case ($urandom % 6)
      0: return 32'd0;
      1: return 32'h7FFF_FFFF;
      2: return 32'h8000_0000;
      3: return 32'hFFFF_FFFF;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1;
    // R11: reset state
    check("R11 reset", {bad_op, flags}, 33'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(T_OP[i], T_A[i], T_B[i], T_K[i]);
      check(tag_of(T_OP[i]), {bad_op, flags}, {T_X[i][4], T_X[i][3:0], 28'd0});
    end

    for (int o = 0; o < 8; o++) begin
      for (int j = 0; j < 300; j++) begin
        logic [31:0] a, b, k;
        a = pick(); b = pick(); k = $urandom;
        if (o == 3 || o == 4) k = {31'd0, k[0]};
        if (o == 5) begin k = {31'd0, k[0]}; b = {31'd0, b[0]}; end
        if (o == 6 || o == 7) k = {30'd0, k[1:0]};
        apply(4'(o), a, b, k);
        check(tag_of(4'(o)), {bad_op, flags}, {1'b0, ref_nzcv(4'(o), a, b, k), 28'd0});
        if (j == 0) check("R10", {5'd0, flags[27:0]}, 33'd0);
      end
    end

    // R9: every undefined tag
    for (int o = 8; o < 16; o++) begin
      apply(4'(o), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd1);
      check("R9", {bad_op, flags}, {1'b1, 32'd0});
    end

    // R11: one-edge latency, then asynchronous reset clears a live result
    @(negedge clk);
    op = 4'd0; dep1 = 32'hF000_0000; dep2 = 0; ndep = 0;
    #1 check("R11 hold", {bad_op, flags}, {1'b1, 32'd0});
    @(negedge clk);
    check("R11 latency", {bad_op, flags}, {1'b0, 32'hF000_0000});
    rst_n = 1'b0;
    #1 check("R11 async reset", {bad_op, flags}, 33'd0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule